// File: doc/BRIEF.md
# GPIO Bank with Interrupt Sensing

This block is a bank of general-purpose pins, 32 by default, reached through a single-cycle register port. Software drives pins through an output-data register and an output-enable register. It reads the synchronized pin levels back through an input register. Every writable register can be updated three ways: a plain write replaces the whole value, the set alias ORs the written ones into it, and the clear alias removes the written ones. Software can therefore change single pins without a read-modify-write sequence.

Each pin can also act as an interrupt source. A select bit lets the pin into the detector. A level bit picks level or edge sensing, and a polarity bit picks high/rising or low/falling. Detected events are latched into a status register whether or not they are enabled. Software clears status bits only through the clear alias of that register. One interrupt line goes high while any status bit is set together with its enable bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero, pin_oe and pin_out are all zero, and irq is low.
- R2: The address is decoded as follows. Bits [ADDR_W-1:4] give the register slot: 0 output data, 1 pin input, 2 output enable, 3 interrupt select, 4 interrupt enable, 5 level select, 6 polarity, 7 status. Bits [3:2] give the access kind: 0 plain, 1 set, 2 clear. A plain write to a writable slot replaces its value, and a read at offset 0, 4 or 8 of that slot returns the value. An address with bits [1:0] nonzero, with kind 3, or with slot 8 or above writes nothing and reads zero.
- R3: A write to the set alias ORs the written ones into the register. A write to the clear alias clears the register bits written as one. All other bits keep their value.
- R4: pin_out equals the output-data register and pin_oe equals the output-enable register, one bit per pin; an enable bit of 1 means the pin is driven.
- R5: The input register returns pin_in delayed by SYNC_STAGES clock edges, whatever the output-enable bits are. Writes to it have no effect.
- R6: When a pin's level bit is 0 (edge mode), a polarity bit of 1 latches its status bit on a 0-to-1 change of the synchronized pin, and 0 latches it on a 1-to-0 change. The status bit becomes visible SYNC_STAGES+1 edges after pin_in changes.
- R7: When a pin's level bit is 1 (level mode), its status bit is set on every edge at which the synchronized pin is at the active level (1 when polarity is 1, 0 when it is 0). A clear issued while the level is still active leaves the bit set.
- R8: A pin whose interrupt-select bit is 0 never sets its status bit.
- R9: Status bits are cleared only by writing ones to the status clear alias (address 0x78). Plain and set writes to the status slot leave it unchanged.
- R10: irq is high exactly when some bit is set in both status and interrupt enable. Status bits latch even when their enable bit is 0.
- R11: When a detected event and a status clear of the same bit fall on the same edge, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (slot, access kind, alignment) |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data, valid in the cycle of a read access |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output-data value driven to the pads |
| pin_oe | output | NPINS | Per-pin drive enable |
| irq | output | 1 | Combined interrupt for the bank |

## Verification
The bench builds the block with its defaults: NPINS=32, ADDR_W=8 and SYNC_STAGES=2. With the full 32-bit width the alias writes and input reads reach the top pin, bit 31, as well as bit 0. ADDR_W=8 leaves exactly the slot field above the access-kind bits, so every slot and alias can be addressed directly. With two synchronizer stages, the input register and the status bits lag pin_in by a short fixed number of edges. The bench samples at exactly those edges, which lets it line up a detected event and a status clear on one edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int SLOT_COUNT = 8;
    localparam int SLOT_BITS  = 3;
    localparam int SLOT_LSB   = 4;
    localparam int WORD_MAX   = 32;

    typedef enum logic [2:0] {
        SLOT_DOUT  = 3'd0,
        SLOT_PIN   = 3'd1,
        SLOT_DIR   = 3'd2,
        SLOT_ISEL  = 3'd3,
        SLOT_IEN   = 3'd4,
        SLOT_ILVL  = 3'd5,
        SLOT_IPOL  = 3'd6,
        SLOT_ISTAT = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef struct packed {
        logic       ok;
        logic [2:0] slot;
        op_e        op;
    } acc_t;

    // Slots backed by plain software-written storage.
    function automatic logic slot_is_stored(int s);
        return (s != int'(SLOT_PIN)) && (s != int'(SLOT_ISTAT));
    endfunction

    function automatic acc_t decode_addr(logic [15:0] a);
        acc_t r;
        r.slot = a[SLOT_LSB +: SLOT_BITS];
        r.op   = op_e'(a[3:2]);
        r.ok   = ((a >> (SLOT_LSB + SLOT_BITS)) == 16'd0) &&
                 (a[1:0] == 2'b00) && (a[3:2] != 2'(OP_NONE));
        return r;
    endfunction

    function automatic logic [WORD_MAX-1:0] merge_word(op_e op,
                                                      logic [WORD_MAX-1:0] cur,
                                                      logic [WORD_MAX-1:0] wd);
        case (op)
            OP_WRITE: return wd;
            OP_SET:   return cur | wd;
            OP_CLR:   return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_async,
    output logic [NPINS-1:0] pin_sync
);

    logic [NPINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= pin_async;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign pin_sync = stage_q[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            // R5: the last stage follows the stage before it by one edge
            assert_sync_chain_R5: assert property (@(posedge clk) disable iff (rst)
                pin_sync == $past(stage_q[STAGES-2]));
        end
    endgenerate

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  acc_t             acc,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] isel_q,
    output logic [NPINS-1:0] ien_q,
    output logic [NPINS-1:0] ilvl_q,
    output logic [NPINS-1:0] ipol_q
);

    generate
        for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
            if (slot_is_stored(s)) begin : g_body
                logic [NPINS-1:0] q;
                logic             hit;
                assign hit = wr && acc.ok && (acc.slot == 3'(s));
                always_ff @(posedge clk) begin
                    if (rst)      q <= '0;
                    else if (hit) q <= NPINS'(merge_word(acc.op,
                                                         WORD_MAX'(q),
                                                         WORD_MAX'(wdata)));
                end
            end
        end
    endgenerate

    assign dout_q = g_slot[0].g_body.q;
    assign dir_q  = g_slot[2].g_body.q;
    assign isel_q = g_slot[3].g_body.q;
    assign ien_q  = g_slot[4].g_body.q;
    assign ilvl_q = g_slot[5].g_body.q;
    assign ipol_q = g_slot[6].g_body.q;

    assert_plain_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.ok && acc.slot == 3'(SLOT_DIR) && acc.op == OP_WRITE)
        |=> (dir_q == $past(wdata)));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.ok && acc.slot == 3'(SLOT_DOUT) && acc.op == OP_SET)
        |=> ((dout_q & $past(wdata)) == $past(wdata)));

    assert_clr_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && acc.ok && acc.slot == 3'(SLOT_DOUT) && acc.op == OP_CLR)
        |=> ((dout_q & $past(wdata)) == '0));

endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_sync,
    input  logic [NPINS-1:0] isel,
    input  logic [NPINS-1:0] ilvl,
    input  logic [NPINS-1:0] ipol,
    input  logic [NPINS-1:0] clr_mask,
    output logic [NPINS-1:0] status_q
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= pin_sync;
    end

    generate
        for (genvar p = 0; p < NPINS; p++) begin : g_pin
            logic rise, fall, lvl_act, edge_act;
            assign rise     = pin_sync[p] & ~prev_q[p];
            assign fall     = ~pin_sync[p] & prev_q[p];
            assign lvl_act  = ~(pin_sync[p] ^ ipol[p]);
            assign edge_act = ipol[p] ? rise : fall;
            assign hit[p]   = isel[p] & (ilvl[p] ? lvl_act : edge_act);
        end
    endgenerate

    // Hardware set takes precedence over a software clear on the same edge.
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_mask) | hit;
    end

    assert_no_silent_clear_R9: assert property (@(posedge clk) disable iff (rst)
        ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));

    assert_select_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~$past(isel)) == '0));

    assert_level_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (($past(isel & ilvl & ~(pin_sync ^ ipol)) & ~status_q) == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    acc_t             acc;
    logic             wr;
    logic [NPINS-1:0] dout, dir, isel, ien, ilvl, ipol;
    logic [NPINS-1:0] pin_sync, status, clr_mask;

    assign acc = decode_addr(16'(bus_addr));
    assign wr  = bus_sel & bus_we;

    gpio_ctrl_regs #(.NPINS(NPINS)) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .acc    (acc),
        .wdata  (bus_wdata),
        .dout_q (dout),
        .dir_q  (dir),
        .isel_q (isel),
        .ien_q  (ien),
        .ilvl_q (ilvl),
        .ipol_q (ipol)
    );

    gpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    assign clr_mask = (wr && acc.ok && acc.slot == 3'(SLOT_ISTAT) && acc.op == OP_CLR)
                      ? bus_wdata : '0;

    gpio_irq_sense #(.NPINS(NPINS)) i_sense (
        .clk      (clk),
        .rst      (rst),
        .pin_sync (pin_sync),
        .isel     (isel),
        .ilvl     (ilvl),
        .ipol     (ipol),
        .clr_mask (clr_mask),
        .status_q (status)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we && acc.ok) begin
            case (slot_e'(acc.slot))
                SLOT_DOUT:  bus_rdata = dout;
                SLOT_PIN:   bus_rdata = pin_sync;
                SLOT_DIR:   bus_rdata = dir;
                SLOT_ISEL:  bus_rdata = isel;
                SLOT_IEN:   bus_rdata = ien;
                SLOT_ILVL:  bus_rdata = ilvl;
                SLOT_IPOL:  bus_rdata = ipol;
                SLOT_ISTAT: bus_rdata = status;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = dout;
    assign pin_oe  = dir;
    assign irq     = |(status & ien);

    assert_irq_has_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status != '0));

endmodule

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;

    localparam int NP = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_irq_port #(.NPINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    function automatic logic [AW-1:0] adr(int slot, int op);
        return AW'(slot * 16 + op * 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    // Samples in the current cycle, without waiting for an edge.
    task automatic rd_now(logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int s = 0; s < 8; s++) begin
            rd(adr(s, 0), v);
            check("R1 reset register", v, 0);
        end
        check("R1 reset pin_out", pin_out, 0);
        check("R1 reset pin_oe", pin_oe, 0);
        check("R1 reset irq", {31'd0, irq}, 0);
    endtask

    task automatic t_plain_write;
        logic [31:0] v;
        wr(adr(2, 0), 32'hA5A5_0F0F);
        rd(adr(2, 0), v); check("R2 plain write dir", v, 32'hA5A5_0F0F);
        rd(adr(2, 1), v); check("R2 read via set alias", v, 32'hA5A5_0F0F);
        wr(adr(5, 0), 32'h1234_5678);
        rd(adr(5, 0), v); check("R2 plain write level", v, 32'h1234_5678);
        wr(adr(5, 0), 0);
        // misaligned and kind-3 accesses are dropped
        wr(adr(0, 0) + 1, 32'hFFFF_FFFF);
        wr(adr(0, 3), 32'hFFFF_FFFF);
        rd(adr(0, 0), v); check("R2 ignored write", v, 0);
        rd(adr(2, 3), v); check("R2 kind-3 read zero", v, 0);
        wr(adr(2, 0), 0);
    endtask

    task automatic t_alias;
        logic [31:0] v;
        wr(adr(0, 0), 32'hF0F0_0000);
        wr(adr(0, 1), 32'h0000_00FF);
        rd(adr(0, 0), v); check("R3 set alias", v, 32'hF0F0_00FF);
        wr(adr(0, 2), 32'hF000_000F);
        rd(adr(0, 0), v); check("R3 clear alias", v, 32'h00F0_00F0);
        check("R4 pin_out", pin_out, 32'h00F0_00F0);
        wr(adr(2, 1), 32'h8000_0001);
        check("R4 pin_oe", pin_oe, 32'h8000_0001);
        wr(adr(4, 1), 32'h0000_0300);
        wr(adr(4, 2), 32'h0000_0100);
        rd(adr(4, 0), v); check("R3 alias on enable", v, 32'h0000_0200);
        wr(adr(4, 0), 0);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk); pin_in = 32'h8000_0001;
        @(negedge clk); rd_now(adr(1, 0), v); check("R5 one edge old", v, 0);
        @(negedge clk); rd_now(adr(1, 0), v); check("R5 two edges new", v, 32'h8000_0001);
        wr(adr(1, 0), 32'h0000_FFFF);
        rd(adr(1, 0), v); check("R5 write ignored", v, 32'h8000_0001);
        @(negedge clk); pin_in = 0;
        edges(3);
        wr(adr(2, 0), 0);
    endtask

    task automatic t_edge;
        logic [31:0] v;
        wr(adr(7, 2), 32'hFFFF_FFFF);
        wr(adr(3, 1), 32'h0000_0030);
        wr(adr(6, 1), 32'h0000_0010);
        @(negedge clk); pin_in[4] = 1;
        @(negedge clk); @(negedge clk);
        rd_now(adr(7, 0), v); check("R6 rise not yet", v, 0);
        @(negedge clk);
        rd_now(adr(7, 0), v); check("R6 rise latched", v, 32'h10);
        @(negedge clk); pin_in[4] = 0;
        edges(4);
        rd(adr(7, 0), v); check("R6 fall ignored when rising", v, 32'h10);
        wr(adr(7, 2), 32'h10);
        @(negedge clk); pin_in[5] = 1;
        edges(4);
        rd(adr(7, 0), v); check("R6 rise ignored when falling", v, 0);
        @(negedge clk); pin_in[5] = 0;
        edges(3);
        rd(adr(7, 0), v); check("R6 fall latched", v, 32'h20);
        wr(adr(7, 2), 32'h20);
    endtask

    task automatic t_level;
        logic [31:0] v;
        wr(adr(5, 1), 32'h0000_0200);
        wr(adr(6, 1), 32'h0000_0200);
        wr(adr(3, 1), 32'h0000_0200);
        @(negedge clk); pin_in[9] = 1;
        edges(4);
        rd(adr(7, 0), v); check("R7 level high latched", v, 32'h200);
        wr(adr(7, 2), 32'h200);
        rd(adr(7, 0), v); check("R7 reasserts while active", v, 32'h200);
        @(negedge clk); pin_in[9] = 0;
        edges(3);
        wr(adr(7, 2), 32'h200);
        edges(3);
        rd(adr(7, 0), v); check("R7 stays clear when inactive", v, 0);
        // active-low level on pin 10, pin held low
        wr(adr(5, 1), 32'h0000_0400);
        wr(adr(3, 1), 32'h0000_0400);
        rd(adr(7, 0), v); check("R7 low level latched", v, 32'h400);
        wr(adr(3, 2), 32'h0000_0600);
        wr(adr(7, 2), 32'hFFFF_FFFF);
        rd(adr(7, 0), v); check("R7 cleared after deselect", v, 0);
    endtask

    task automatic t_select;
        logic [31:0] v;
        wr(adr(6, 1), 32'h0000_1000);
        @(negedge clk); pin_in[12] = 1;
        edges(4);
        @(negedge clk); pin_in[12] = 0;
        edges(4);
        rd(adr(7, 0), v); check("R8 unselected pin silent", v, 0);
        check("R8 irq quiet", {31'd0, irq}, 0);
    endtask

    task automatic t_status_writes;
        logic [31:0] v;
        @(negedge clk); pin_in[4] = 1;
        edges(3);
        wr(adr(7, 0), 0);
        rd(adr(7, 0), v); check("R9 plain write ignored", v, 32'h10);
        wr(adr(7, 1), 32'hFFFF_FFFF);
        rd(adr(7, 0), v); check("R9 set write ignored", v, 32'h10);
        wr(adr(7, 2), 32'h10);
        rd(adr(7, 0), v); check("R9 clear alias clears", v, 0);
        @(negedge clk); pin_in[4] = 0;
        edges(4);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        @(negedge clk); pin_in[4] = 1;
        edges(3);
        rd(adr(7, 0), v); check("R10 status latched while masked", v, 32'h10);
        check("R10 irq masked", {31'd0, irq}, 0);
        wr(adr(4, 1), 32'h10);
        check("R10 irq enabled", {31'd0, irq}, 1);
        wr(adr(4, 2), 32'h10);
        check("R10 irq masked again", {31'd0, irq}, 0);
        wr(adr(4, 1), 32'h10);
        wr(adr(7, 2), 32'h10);
        check("R10 irq drops on clear", {31'd0, irq}, 0);
        wr(adr(4, 0), 0);
        @(negedge clk); pin_in[4] = 0;
        edges(4);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(adr(7, 2), 32'hFFFF_FFFF);
        @(negedge clk); pin_in[4] = 1;
        @(negedge clk); @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = adr(7, 2); bus_wdata = 32'h10;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
        rd_now(adr(7, 0), v); check("R11 set wins over clear", v, 32'h10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_plain_write();
        t_alias();
        t_input();
        t_edge();
        t_level();
        t_select();
        t_status_writes();
        t_irq();
        t_collide();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule